// File: doc/BRIEF.md
# Transactional MESI Line State Controller

This block keeps the coherence state of every line of a small private L1 cache. Besides the four MESI states, each line can be in a transactional state. Five are added: three transactional twins of Modified, Exclusive and Shared, a speculatively written state that holds isolated stores, and an isolated invalid state. These let several transactions read and write the same line at once without seeing each other's stores. The data array, bus arbitration, the shared level below and the software policy are outside the block.

In each cycle the controller can accept one local request, one snooped bus request, one eviction request and a commit or abort pulse. The local request is a load, a store, a transactional load or a transactional store. The snooped request is a read or a read-for-ownership. The controller answers the snoop at once, reporting threatened, suppressed or supplied data. It tells the cache which bus request the local access needs, and it updates the line states on the next clock edge. Commit and abort act only inside this cache. On that edge every transactional line returns to plain MESI.

A line that holds transactional stores cannot be evicted. When the cache tries to evict one, the controller keeps the line and raises a sticky overflow flag, so that software can fall back to a slower path.

Top module: `tmesi_ctrl`

## Requirements
- R1: After reset every line reads state code 0 (I), overflow is 0 and the local bus request is 0 (none). State codes are I=0, S=1, E=2, M=3, TII=4, TSS=5, TEE=6, TMM=7, TMI=8.
- R2: A plain load (op 0) to an I line asks for a bus read (bus code 1). It installs S when lcl_shared is 1 and E otherwise. A load to any other state leaves the line unchanged and asks for nothing. A plain store (op 1) to I or S asks for a read-for-ownership (bus code 2) and gives M. A store to E or M gives M silently. A store to TSS or TII asks for bus code 2 and gives TMM. A store to TEE or TMM gives TMM silently, and a store to TMI leaves TMI.
- R3: A transactional load (op 2) to I asks for bus code 1. It installs TII when lcl_threat is 1, otherwise TSS when lcl_shared is 1, otherwise TEE. It moves S, E and M to TSS, TEE and TMM silently and leaves transactional states as they are.
- R4: A transactional store (op 3) always ends in TMI. It asks for bus code 2 from I, S, TSS and TII, and asks for nothing from E, M, TEE, TMM and TMI.
- R5: A snooped read-for-ownership (snp_op 1) moves TMM, TEE and TSS to TII, and moves M, E and S to I. Data is supplied only from M and TMM.
- R6: A TMI line ignores a snooped read-for-ownership. It stays TMI and supplies no data.
- R7: A snooped read (snp_op 0) of a TMI line raises threat and suppress, supplies no data and leaves the line in TMI. No other state raises either signal.
- R8: A snooped read moves M and E to S, and TMM and TEE to TSS. It supplies data from M and TMM only and leaves S, TSS, TII and I unchanged.
- R9: On commit, TMI and TMM become M, TEE becomes E, TSS becomes S and TII becomes I. Plain states stay as they are, and every line changes on the same edge.
- R10: On abort, TMI becomes I and the other transactional states map as for commit. When commit and abort come together, abort wins.
- R11: Evicting a line that is not TMI makes it I and leaves overflow unchanged. Evicting a TMI line leaves it in TMI and sets overflow, which stays 1 until the next commit or abort clears it.
- R12: Commit and abort cause no bus request. The bus request is 0 whenever lcl_valid is 0.
- R13: When several events meet one line in the same cycle, they apply in this order: snoop, local request, eviction, then commit or abort. The local bus request is worked out from the state the snoop leaves behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request present |
| lcl_op | input | 2 | 0 load, 1 store, 2 transactional load, 3 transactional store |
| lcl_idx | input | IDX_W | Line addressed by the local request |
| lcl_shared | input | 1 | Bus read response said another cache holds the line |
| lcl_threat | input | 1 | Bus read response came back threatened |
| snp_valid | input | 1 | Snooped request present |
| snp_op | input | 1 | 0 read, 1 read-for-ownership |
| snp_idx | input | IDX_W | Line hit by the snoop |
| commit | input | 1 | Local transaction commits |
| abort | input | 1 | Local transaction aborts |
| evict_valid | input | 1 | Eviction request |
| evict_idx | input | IDX_W | Line to evict |
| lcl_bus_op | output | 2 | Bus request for the local access: 0 none, 1 read, 2 read-for-ownership |
| snp_threat | output | 1 | Threatened response to the snoop |
| snp_suppress | output | 1 | Data reply to the snoop withheld |
| snp_supply | output | 1 | This cache supplies the snooped data |
| overflow | output | 1 | Sticky: a speculatively written line could not be evicted |
| line_states | output | 4*NUM_LINES | State code of each line, line n at bits 4n+3..4n |

## Verification
The hardest case to reach is a line that meets a snoop, a local access and an eviction or flash in the same cycle, because each event sees the state the one before it left. The bench first drives each line into every one of the nine states using only local requests, then sweeps every snoop and local operation over those states. It then adds targeted collisions: a read-for-ownership together with a transactional store on TEE, eviction of TMI together with commit, and commit together with abort. A mixed load with eight lines in eight different states checks that commit and abort change all lines on the same edge.

// File: rtl/tmesi_pkg.sv
package tmesi_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    ST_I   = 4'd0,
    ST_S   = 4'd1,
    ST_E   = 4'd2,
    ST_M   = 4'd3,
    ST_TII = 4'd4,
    ST_TSS = 4'd5,
    ST_TEE = 4'd6,
    ST_TMM = 4'd7,
    ST_TMI = 4'd8
  } line_st_e;

  typedef enum logic [1:0] {
    OP_LD  = 2'd0,
    OP_ST  = 2'd1,
    OP_TLD = 2'd2,
    OP_TST = 2'd3
  } lcl_op_e;

  typedef enum logic {
    SNP_RD  = 1'b0,
    SNP_RDX = 1'b1
  } snp_op_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2
  } bus_op_e;

  typedef struct packed {
    logic threat;
    logic suppress;
    logic supply;
  } snp_resp_t;

  function automatic logic is_txn(line_st_e s);
    return (s == ST_TII) || (s == ST_TSS) || (s == ST_TEE) ||
           (s == ST_TMM) || (s == ST_TMI);
  endfunction

  // State left behind by a snooped request.
  function automatic line_st_e snoop_next(line_st_e s, snp_op_e op);
    line_st_e r;
    r = s;
    if (op == SNP_RD) begin
      case (s)
        ST_M, ST_E:     r = ST_S;
        ST_TMM, ST_TEE: r = ST_TSS;
        default:        r = s;
      endcase
    end else begin
      case (s)
        ST_M, ST_E, ST_S:       r = ST_I;
        ST_TMM, ST_TEE, ST_TSS: r = ST_TII;
        default:                r = s;  // I, TII, TMI unaffected
      endcase
    end
    return r;
  endfunction

  function automatic snp_resp_t snoop_resp(line_st_e s, snp_op_e op);
    snp_resp_t r;
    r.threat   = (op == SNP_RD) && (s == ST_TMI);
    r.suppress = (op == SNP_RD) && (s == ST_TMI);
    r.supply   = (s == ST_M) || (s == ST_TMM);
    return r;
  endfunction

  // State left behind by a local access.
  function automatic line_st_e local_next(line_st_e s, lcl_op_e op,
                                          logic shared, logic threat);
    line_st_e r;
    r = s;
    case (op)
      OP_LD: begin
        if (s == ST_I) r = shared ? ST_S : ST_E;
      end
      OP_ST: begin
        if (s == ST_TMI)    r = ST_TMI;
        else if (is_txn(s)) r = ST_TMM;
        else                r = ST_M;
      end
      OP_TLD: begin
        case (s)
          ST_I:    r = threat ? ST_TII : (shared ? ST_TSS : ST_TEE);
          ST_S:    r = ST_TSS;
          ST_E:    r = ST_TEE;
          ST_M:    r = ST_TMM;
          default: r = s;
        endcase
      end
      default: r = ST_TMI;
    endcase
    return r;
  endfunction

  // Bus request a local access needs from a given state.
  function automatic bus_op_e local_bus(line_st_e s, lcl_op_e op);
    logic needs_own;
    needs_own = (s == ST_I) || (s == ST_S) || (s == ST_TSS) || (s == ST_TII);
    case (op)
      OP_LD, OP_TLD: return (s == ST_I) ? BUS_RD : BUS_NONE;
      default:       return needs_own ? BUS_RDX : BUS_NONE;
    endcase
  endfunction

  // Flash return to plain MESI on commit or abort.
  function automatic line_st_e flash_next(line_st_e s, logic is_abort);
    case (s)
      ST_TMI:  return is_abort ? ST_I : ST_M;
      ST_TMM:  return ST_M;
      ST_TEE:  return ST_E;
      ST_TSS:  return ST_S;
      ST_TII:  return ST_I;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/tmesi_line.sv
module tmesi_line
  import tmesi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snp_hit,
  input  logic            snp_op,
  input  logic            lcl_hit,
  input  logic [1:0]      lcl_op,
  input  logic            lcl_shared,
  input  logic            lcl_threat,
  input  logic            evict_hit,
  input  logic            commit,
  input  logic            abort,
  output logic [ST_W-1:0] state_o,
  output logic [ST_W-1:0] post_snoop_o,
  output logic            evict_refused_o
);

  line_st_e st_q;
  line_st_e after_snp;
  line_st_e after_lcl;
  line_st_e after_evict;
  line_st_e st_d;
  logic     flash;

  assign flash = commit | abort;

  always_comb begin
    after_snp       = snp_hit ? snoop_next(st_q, snp_op_e'(snp_op)) : st_q;
    after_lcl       = lcl_hit ? local_next(after_snp, lcl_op_e'(lcl_op),
                                           lcl_shared, lcl_threat)
                              : after_snp;
    evict_refused_o = evict_hit && (after_lcl == ST_TMI);
    after_evict     = (evict_hit && !evict_refused_o) ? ST_I : after_lcl;
    st_d            = flash ? flash_next(after_evict, abort) : after_evict;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_I;
    else        st_q <= st_d;
  end

  assign state_o      = st_q;
  assign post_snoop_o = after_snp;

  AST_COMMIT_LEAVES_MESI: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !abort) |=> !is_txn(st_q)); // R9

  AST_ABORT_DROPS_TMI: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && st_q == ST_TMI) |=> (st_q == ST_I)); // R10

  AST_TMI_IGNORES_RDX: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_op && st_q == ST_TMI && !flash) |=> (st_q == ST_TMI)); // R6

  AST_RDX_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_op && !lcl_hit && !evict_hit && !flash &&
     (st_q == ST_TMM || st_q == ST_TEE || st_q == ST_TSS))
    |=> (st_q == ST_TII)); // R5

  AST_EVICT_KEEPS_TMI: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_hit && st_q == ST_TMI && !flash) |=> (st_q == ST_TMI)); // R11

endmodule

// File: rtl/tmesi_snoop_port.sv
module tmesi_snoop_port
  import tmesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                snp_valid,
  input  logic                                snp_op,
  input  logic [IDX_W-1:0]                    snp_idx,
  input  logic [NUM_LINES-1:0][ST_W-1:0]      cur_states,
  output logic                                snp_threat,
  output logic                                snp_suppress,
  output logic                                snp_supply
);

  line_st_e  hit_state;
  snp_resp_t resp;

  always_comb begin
    hit_state = line_st_e'(cur_states[snp_idx]);
    resp      = snoop_resp(hit_state, snp_op_e'(snp_op));
    if (!snp_valid) resp = '0;
  end

  assign snp_threat   = resp.threat;
  assign snp_suppress = resp.suppress;
  assign snp_supply   = resp.supply;

  AST_SUPPRESS_IS_THREATENED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_suppress |-> (snp_threat && !snp_supply)); // R7

  AST_NO_RESP_WITHOUT_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> !(snp_threat || snp_suppress || snp_supply)); // R8

endmodule

// File: rtl/tmesi_req_port.sv
module tmesi_req_port
  import tmesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                lcl_valid,
  input  logic [1:0]                          lcl_op,
  input  logic [IDX_W-1:0]                    lcl_idx,
  input  logic [NUM_LINES-1:0][ST_W-1:0]      post_snoop,
  input  logic                                commit,
  input  logic                                abort,
  output logic [1:0]                          lcl_bus_op
);

  line_st_e base_state;

  always_comb begin
    base_state = line_st_e'(post_snoop[lcl_idx]);
    lcl_bus_op = lcl_valid ? local_bus(base_state, lcl_op_e'(lcl_op)) : BUS_NONE;
  end

  AST_BUS_ONLY_FOR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_bus_op != BUS_NONE) |-> lcl_valid); // R12

  AST_FLASH_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit || abort) && !lcl_valid) |-> (lcl_bus_op == BUS_NONE)); // R12

endmodule

// File: rtl/tmesi_ctrl.sv
module tmesi_ctrl
  import tmesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lcl_valid,
  input  logic [1:0]                lcl_op,
  input  logic [IDX_W-1:0]          lcl_idx,
  input  logic                      lcl_shared,
  input  logic                      lcl_threat,
  input  logic                      snp_valid,
  input  logic                      snp_op,
  input  logic [IDX_W-1:0]          snp_idx,
  input  logic                      commit,
  input  logic                      abort,
  input  logic                      evict_valid,
  input  logic [IDX_W-1:0]          evict_idx,
  output logic [1:0]                lcl_bus_op,
  output logic                      snp_threat,
  output logic                      snp_suppress,
  output logic                      snp_supply,
  output logic                      overflow,
  output logic [NUM_LINES*ST_W-1:0] line_states
);

  logic [NUM_LINES-1:0][ST_W-1:0] cur_states;
  logic [NUM_LINES-1:0][ST_W-1:0] post_snoop;
  logic [NUM_LINES-1:0]           evict_refused;
  logic                           ovf_event;
  logic                           ovf_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic snp_hit_w;
    logic lcl_hit_w;
    logic evict_hit_w;

    assign snp_hit_w   = snp_valid   && (snp_idx   == IDX_W'(g));
    assign lcl_hit_w   = lcl_valid   && (lcl_idx   == IDX_W'(g));
    assign evict_hit_w = evict_valid && (evict_idx == IDX_W'(g));

    tmesi_line u_line (
      .clk             (clk),
      .rst_n           (rst_n),
      .snp_hit         (snp_hit_w),
      .snp_op          (snp_op),
      .lcl_hit         (lcl_hit_w),
      .lcl_op          (lcl_op),
      .lcl_shared      (lcl_shared),
      .lcl_threat      (lcl_threat),
      .evict_hit       (evict_hit_w),
      .commit          (commit),
      .abort           (abort),
      .state_o         (cur_states[g]),
      .post_snoop_o    (post_snoop[g]),
      .evict_refused_o (evict_refused[g])
    );
  end

  tmesi_snoop_port #(.NUM_LINES(NUM_LINES)) u_snoop (
    .clk          (clk),
    .rst_n        (rst_n),
    .snp_valid    (snp_valid),
    .snp_op       (snp_op),
    .snp_idx      (snp_idx),
    .cur_states   (cur_states),
    .snp_threat   (snp_threat),
    .snp_suppress (snp_suppress),
    .snp_supply   (snp_supply)
  );

  tmesi_req_port #(.NUM_LINES(NUM_LINES)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcl_valid  (lcl_valid),
    .lcl_op     (lcl_op),
    .lcl_idx    (lcl_idx),
    .post_snoop (post_snoop),
    .commit     (commit),
    .abort      (abort),
    .lcl_bus_op (lcl_bus_op)
  );

  assign ovf_event = |evict_refused;

  always_ff @(posedge clk) begin
    if (!rst_n)                ovf_q <= 1'b0;
    else if (commit || abort)  ovf_q <= 1'b0;
    else if (ovf_event)        ovf_q <= 1'b1;
  end

  assign overflow    = ovf_q;
  assign line_states = cur_states;

  AST_NO_OVERFLOW_WITHOUT_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(evict_valid)); // R11

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !commit && !abort) |=> overflow); // R11

  AST_FLASH_CLEARS_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |=> !overflow); // R11

endmodule

// File: tb/test_tmesi_ctrl.sv
module test_tmesi_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int IW = 3;

  localparam int B_I = 0, B_S = 1, B_E = 2, B_M = 3, B_TII = 4,
                 B_TSS = 5, B_TEE = 6, B_TMM = 7, B_TMI = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lcl_valid = 1'b0;
  logic [1:0] lcl_op = '0;
  logic [IW-1:0] lcl_idx = '0;
  logic lcl_shared = 1'b0;
  logic lcl_threat = 1'b0;
  logic snp_valid = 1'b0;
  logic snp_op = 1'b0;
  logic [IW-1:0] snp_idx = '0;
  logic commit = 1'b0;
  logic abort = 1'b0;
  logic evict_valid = 1'b0;
  logic [IW-1:0] evict_idx = '0;
  logic [1:0] lcl_bus_op;
  logic snp_threat, snp_suppress, snp_supply, overflow;
  logic [NL*4-1:0] line_states;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmesi_ctrl #(.NUM_LINES(NL)) i_tmesi_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_idx(lcl_idx),
    .lcl_shared(lcl_shared), .lcl_threat(lcl_threat),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
    .commit(commit), .abort(abort),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .lcl_bus_op(lcl_bus_op), .snp_threat(snp_threat),
    .snp_suppress(snp_suppress), .snp_supply(snp_supply),
    .overflow(overflow), .line_states(line_states)
  );

  // ---------------- expected-value model ----------------
  function automatic bit txn(int s);
    return s >= B_TII;
  endfunction

  function automatic int plain_of(int s);
    // transactional state -> MESI twin; TII -> I
    if (s == B_TMI || s == B_TMM) return B_M;
    if (s == B_TEE) return B_E;
    if (s == B_TSS) return B_S;
    if (s == B_TII) return B_I;
    return s;
  endfunction

  function automatic int m_flash(int s, bit ab);
    if (s == B_TMI && ab) return B_I;
    return plain_of(s);
  endfunction

  function automatic int m_snp_next(int s, int op);
    bit owner = (s == B_M) || (s == B_E) || (s == B_TMM) || (s == B_TEE);
    if (s == B_I || s == B_TII || s == B_TMI) return s;
    if (op == 0) return owner ? (txn(s) ? B_TSS : B_S) : s;
    return txn(s) ? B_TII : B_I;
  endfunction

  function automatic int m_lcl_next(int s, int op, bit sh, bit th);
    if (op == 3) return B_TMI;
    if (op == 0) return (s == B_I) ? (sh ? B_S : B_E) : s;
    if (op == 1) return (s == B_TMI) ? B_TMI : (txn(s) ? B_TMM : B_M);
    if (s == B_I) return th ? B_TII : (sh ? B_TSS : B_TEE);
    if (txn(s)) return s;
    return s + 4;  // S/E/M -> TSS/TEE/TMM
  endfunction

  function automatic int m_lcl_bus(int s, int op);
    if (op == 0 || op == 2) return (s == B_I) ? 1 : 0;
    return (s == B_I || s == B_S || s == B_TSS || s == B_TII) ? 2 : 0;
  endfunction

  function automatic int st_of(int idx);
    return int'(line_states[idx*4 +: 4]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #1;
    lcl_valid = 0; snp_valid = 0; evict_valid = 0; commit = 0; abort = 0;
    lcl_shared = 0; lcl_threat = 0;
  endtask

  task automatic lcl_pulse(int idx, int op, bit sh, bit th);
    lcl_valid = 1; lcl_op = 2'(op); lcl_idx = IW'(idx);
    lcl_shared = sh; lcl_threat = th;
    tick();
  endtask

  task automatic set_from_i(int idx, int s);
    case (s)
      B_S:   lcl_pulse(idx, 0, 1, 0);
      B_E:   lcl_pulse(idx, 0, 0, 0);
      B_M:   lcl_pulse(idx, 1, 0, 0);
      B_TII: lcl_pulse(idx, 2, 0, 1);
      B_TSS: lcl_pulse(idx, 2, 1, 0);
      B_TEE: lcl_pulse(idx, 2, 0, 0);
      B_TMM: begin lcl_pulse(idx, 1, 0, 0); lcl_pulse(idx, 2, 0, 0); end
      B_TMI: lcl_pulse(idx, 3, 0, 0);
      default: ;
    endcase
  endtask

  task automatic reach(int idx, int s);
    abort = 1; tick();
    evict_valid = 1; evict_idx = IW'(idx); tick();
    set_from_i(idx, s);
    check("R2/R3/R4 setup", st_of(idx), s);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    for (int i = 0; i < NL; i++) check("R1 state", st_of(i), B_I);
    check("R1 overflow", int'(overflow), 0);
    check("R1 bus", int'(lcl_bus_op), 0);

    // R2 R3 R4: local sweep over every state, op and response
    for (int s = 0; s < 9; s++)
      for (int op = 0; op < 4; op++)
        for (int c = 0; c < 3; c++) begin
          bit sh = (c == 1);
          bit th = (c == 2);
          reach(3, s);
          lcl_valid = 1; lcl_op = 2'(op); lcl_idx = 3'd3;
          lcl_shared = sh; lcl_threat = th;
          #1;
          check(op < 2 ? "R2 bus" : (op == 2 ? "R3 bus" : "R4 bus"),
                int'(lcl_bus_op), m_lcl_bus(s, op));
          tick();
          check(op < 2 ? "R2 state" : (op == 2 ? "R3 state" : "R4 state"),
                st_of(3), m_lcl_next(s, op, sh, th));
        end

    // R5 R6 R7 R8: snoop sweep
    for (int s = 0; s < 9; s++)
      for (int op = 0; op < 2; op++) begin
        reach(2, s);
        snp_valid = 1; snp_op = op[0]; snp_idx = 3'd2;
        #1;
        check("R7 threat", int'(snp_threat), (op == 0 && s == B_TMI) ? 1 : 0);
        check("R7 suppress", int'(snp_suppress), (op == 0 && s == B_TMI) ? 1 : 0);
        check(op == 0 ? "R8 supply" : "R5 R6 supply", int'(snp_supply),
              (s == B_M || s == B_TMM) ? 1 : 0);
        tick();
        check(op == 0 ? "R8 state" : (s == B_TMI ? "R6 state" : "R5 state"),
              st_of(2), m_snp_next(s, op));
      end

    // R9 R10: per-state flash
    for (int s = 0; s < 9; s++)
      for (int ab = 0; ab < 2; ab++) begin
        reach(5, s);
        if (ab == 1) abort = 1; else commit = 1;
        tick();
        check(ab == 1 ? "R10 state" : "R9 state", st_of(5), m_flash(s, ab == 1));
      end

    // R9 R10: eight lines in eight states flash on the same edge
    for (int ab = 0; ab < 2; ab++) begin
      abort = 1; tick();
      for (int i = 0; i < NL; i++) begin
        evict_valid = 1; evict_idx = IW'(i); tick();
      end
      for (int i = 0; i < NL; i++) set_from_i(i, i + 1);
      if (ab == 1) abort = 1; else commit = 1;
      #1;
      check("R12 no bus on flash", int'(lcl_bus_op), 0);
      tick();
      for (int i = 0; i < NL; i++)
        check(ab == 1 ? "R10 multi" : "R9 multi", st_of(i), m_flash(i + 1, ab == 1));
    end

    // R11: eviction sweep
    for (int s = 0; s < 9; s++) begin
      reach(4, s);
      evict_valid = 1; evict_idx = 3'd4;
      tick();
      check("R11 evict state", st_of(4), (s == B_TMI) ? B_TMI : B_I);
      check("R11 overflow", int'(overflow), (s == B_TMI) ? 1 : 0);
    end
    // overflow sticky, then cleared by commit
    tick();
    check("R11 overflow held", int'(overflow), 1);
    commit = 1; tick();
    check("R11 overflow cleared", int'(overflow), 0);
    check("R11 line after commit", st_of(4), B_M);

    // R13: snoop then local on one line in one cycle
    reach(1, B_TEE);
    snp_valid = 1; snp_op = 1; snp_idx = 3'd1;
    lcl_valid = 1; lcl_op = 2'd3; lcl_idx = 3'd1;
    #1;
    check("R13 bus after snoop", int'(lcl_bus_op), 2);
    check("R13 no supply from TEE", int'(snp_supply), 0);
    tick();
    check("R13 state", st_of(1), B_TMI);

    // R13: eviction before commit on TMI
    reach(1, B_TMI);
    evict_valid = 1; evict_idx = 3'd1; commit = 1;
    tick();
    check("R13 evict+commit state", st_of(1), B_M);
    check("R13 evict+commit overflow", int'(overflow), 0);

    // R10: abort wins over commit
    reach(1, B_TMI);
    commit = 1; abort = 1;
    tick();
    check("R10 abort wins", st_of(1), B_I);

    // R12: bus idle when no local request, even with snoop and commit
    reach(6, B_TSS);
    snp_valid = 1; snp_op = 1; snp_idx = 3'd6; commit = 1;
    #1;
    check("R12 idle bus", int'(lcl_bus_op), 0);
    tick();
    check("R12 state", st_of(6), B_I);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule